// File: doc/BRIEF.md
# Media-Extension Instruction Legality Checker

This block is the legality stage for a 64-bit packed SIMD media coprocessor extension. Each cycle it may receive one 32-bit instruction word, marked by a valid strobe. With the word come four status bits: coprocessor 1 usable, media enable, 64-bit operation enable and vendor-extension enable. The block sorts the word into one of six kinds: accumulator read, accumulator write, absolute difference, absolute-difference-accumulate, average, or not handled. It then applies the exception checks in a fixed priority order.

One clock after the strobe, the block gives a one-cycle result. The result holds a done pulse, an issue pulse, a two-bit exception code, the op kind, the register fields pulled from the word and the format field. Downstream logic uses the issue pulse to start the datapath, or takes the exception code into the trap logic. An accumulator read or write that passes every check issues as a no-op, and a separate output flags this. The arithmetic, the vector register file and the accumulator contents live elsewhere.

Top module: `mx_legal_check`

## Requirements
- R1: A word whose bits 31:26 are not 011110 is reported as not handled: kind 0, exception code 0 and no issue.
- R2: With bits 31:26 equal to 011110, bits 5:0 choose the kind. The code is 1 for accumulator read (111111), 2 for accumulator write (111110), 3 for absolute difference (001001), 4 for absolute-difference-accumulate (110101) and 5 for average (001000). Any other value gives kind 0.
- R3: For every handled kind, the checks run in a fixed order. Coprocessor 1 not usable gives code 1. Otherwise, media enable clear gives code 2. Otherwise, 64-bit operations disabled gives code 3.
- R4: After the checks in R3, the three vendor kinds (3, 4, 5) with vendor enable clear give code 3, whatever their format. The accumulator kinds ignore vendor enable.
- R5: For vendor kinds, bits 22:21 of the format-select field are decoded. Values 00 and 10 are accepted. Values 01 and 11 give code 3. Bits 25:23 do not affect legality.
- R6: For accumulator kinds, bit 21 set gives code 3.
- R7: An accumulator read is handled only when bits 20:16 and bits 15:11 are both zero. Bits 25:24 give the slice (00 low, 01 middle, 10 high, 11 combined) and appear on the slice output.
- R8: An accumulator write is handled only when bits 10:6 are zero. A high-slice write (bits 25:24 = 10) also needs bits 20:16 to be zero. A low-slice write accepts any bits 20:16 as a second source.
- R9: The single-slice forms need bits 23:22 to be nonzero, or the word is not handled. These are reads with slice 00, 01 or 10, and writes with slice 00 or 10. The combined forms accept any bits 23:22.
- R10: Absolute-difference-accumulate is handled only when bits 10:6 are zero.
- R11: The exception codes are 0 none, 1 coprocessor unusable, 2 media disabled and 3 reserved instruction. Issue is high exactly when the kind is nonzero and the code is 0.
- R12: All outputs are registered. Done, issue, no-op and a nonzero exception code appear for exactly the one cycle after a valid strobe. The no-op flag marks issued accumulator kinds. vd, vs, vt and fmt carry bits 10:6, 15:11, 20:16 and 25:21. A synchronous reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 32 | Instruction word |
| cop1_usable_i | input | 1 | Coprocessor 1 usable |
| media_en_i | input | 1 | Media extension enabled |
| wide_en_i | input | 1 | 64-bit operations enabled |
| vext_en_i | input | 1 | Vendor extension ops enabled |
| done_o | output | 1 | Result valid pulse |
| issue_o | output | 1 | Op may issue |
| nop_o | output | 1 | Issued op completes as a no-op |
| exc_o | output | 2 | Exception code |
| class_o | output | 3 | Op kind |
| slice_o | output | 2 | Accumulator slice select |
| vd_o | output | 5 | Destination field |
| vs_o | output | 5 | First source field |
| vt_o | output | 5 | Second source field |
| fmt_o | output | 5 | Format-select field |

## Verification
The bench goes after the ordering of the checks. It clears several enables at once and expects the highest-priority code. A design with a swapped order would report media-disabled where the coprocessor must win. It probes format values 01 and 11 and the ignored upper format bits, which catches a decoder that tests the wrong bit or all five bits. It sets stray bits in the must-be-zero fields of each accumulator form and of the accumulate form, and clears bits 23:22 on the single-slice forms. A partial decode that misses one of these would issue a word it should reject. It clears the vendor enable on accumulator ops too, so a gate applied to every kind would wrongly trap them.

// File: rtl/mx_pkg.sv
package mx_pkg;

  localparam int unsigned IW       = 32;
  localparam int unsigned RW       = 5;
  localparam int unsigned FW       = 6;
  localparam logic [FW-1:0] MAJOR_MEDIA = 6'b011110;

  localparam logic [FW-1:0] FN_ACC_RD   = 6'b111111;
  localparam logic [FW-1:0] FN_ACC_WR   = 6'b111110;
  localparam logic [FW-1:0] FN_ABSD     = 6'b001001;
  localparam logic [FW-1:0] FN_ABSD_ACC = 6'b110101;
  localparam logic [FW-1:0] FN_AVG      = 6'b001000;

  localparam logic [1:0] SL_LOW  = 2'b00;
  localparam logic [1:0] SL_MID  = 2'b01;
  localparam logic [1:0] SL_HIGH = 2'b10;
  localparam logic [1:0] SL_ALL  = 2'b11;

  typedef enum logic [2:0] {
    OPC_NONE     = 3'd0,
    OPC_ACC_RD   = 3'd1,
    OPC_ACC_WR   = 3'd2,
    OPC_ABSD     = 3'd3,
    OPC_ABSD_ACC = 3'd4,
    OPC_AVG      = 3'd5
  } op_class_e;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_CPU   = 2'd1,
    EXC_MEDIA = 2'd2,
    EXC_RSVD  = 2'd3
  } exc_e;

  typedef struct packed {
    logic [1:0]    slice;
    logic [RW-1:0] vd;
    logic [RW-1:0] vs;
    logic [RW-1:0] vt;
    logic [RW-1:0] fmt;
  } mx_fields_t;

  function automatic logic [FW-1:0] f_major(input logic [IW-1:0] w);
    return w[31:26];
  endfunction

  function automatic logic [FW-1:0] f_func(input logic [IW-1:0] w);
    return w[5:0];
  endfunction

  function automatic logic [1:0] f_slice(input logic [IW-1:0] w);
    return w[25:24];
  endfunction

  function automatic logic [1:0] f_sub(input logic [IW-1:0] w);
    return w[23:22];
  endfunction

  // Packed-byte accepted when the low format bit is clear (00 or 10).
  function automatic logic f_vendor_fmt_ok(input logic [IW-1:0] w);
    return (w[22:21] == 2'b00) || (w[22:21] == 2'b10);
  endfunction

  function automatic logic f_acc_fmt_ok(input logic [IW-1:0] w);
    return !w[21];
  endfunction

  function automatic logic f_is_vendor(input op_class_e c);
    return (c == OPC_ABSD) || (c == OPC_ABSD_ACC) || (c == OPC_AVG);
  endfunction

  function automatic logic f_is_acc(input op_class_e c);
    return (c == OPC_ACC_RD) || (c == OPC_ACC_WR);
  endfunction

endpackage

// File: rtl/mx_op_decode.sv
module mx_op_decode
  import mx_pkg::*;
(
  input  logic [IW-1:0] instr,
  output op_class_e     cls,
  output logic          fmt_ok
);

  logic major_hit;
  logic rd_shape, wr_shape, absd_acc_shape;
  logic rd_sub_ok, wr_sub_ok;
  logic [1:0] sl;

  assign major_hit = (f_major(instr) == MAJOR_MEDIA);
  assign sl        = f_slice(instr);

  // Single-slice forms need a nonzero sub field; the combined forms do not.
  always_comb begin
    rd_sub_ok = (sl == SL_ALL) || (f_sub(instr) != 2'b00);
    unique case (sl)
      SL_LOW, SL_HIGH: wr_sub_ok = (f_sub(instr) != 2'b00);
      default:         wr_sub_ok = 1'b1;
    endcase
  end

  assign rd_shape = (instr[20:16] == '0) && (instr[15:11] == '0) && rd_sub_ok;
  assign wr_shape = (instr[10:6] == '0) && wr_sub_ok &&
                    ((sl != SL_HIGH) || (instr[20:16] == '0));
  assign absd_acc_shape = (instr[10:6] == '0);

  always_comb begin
    cls = OPC_NONE;
    if (major_hit) begin
      unique case (f_func(instr))
        FN_ACC_RD:   cls = rd_shape       ? OPC_ACC_RD   : OPC_NONE;
        FN_ACC_WR:   cls = wr_shape       ? OPC_ACC_WR   : OPC_NONE;
        FN_ABSD:     cls = OPC_ABSD;
        FN_ABSD_ACC: cls = absd_acc_shape ? OPC_ABSD_ACC : OPC_NONE;
        FN_AVG:      cls = OPC_AVG;
        default:     cls = OPC_NONE;
      endcase
    end
  end

  always_comb begin
    if (f_is_vendor(cls))   fmt_ok = f_vendor_fmt_ok(instr);
    else if (f_is_acc(cls)) fmt_ok = f_acc_fmt_ok(instr);
    else                    fmt_ok = 1'b1;
  end

endmodule

// File: rtl/mx_exc_prio.sv
module mx_exc_prio
  import mx_pkg::*;
(
  input  op_class_e cls,
  input  logic      fmt_ok,
  input  logic      cop1_usable,
  input  logic      media_en,
  input  logic      wide_en,
  input  logic      vext_en,
  output exc_e      exc
);

  logic vendor_gate;
  assign vendor_gate = f_is_vendor(cls) && !vext_en;

  always_comb begin
    if (cls == OPC_NONE)  exc = EXC_NONE;
    else if (!cop1_usable) exc = EXC_CPU;
    else if (!media_en)    exc = EXC_MEDIA;
    else if (!wide_en)     exc = EXC_RSVD;
    else if (vendor_gate)  exc = EXC_RSVD;   // format left unexamined
    else if (!fmt_ok)      exc = EXC_RSVD;
    else                   exc = EXC_NONE;
  end

endmodule

// File: rtl/mx_field_extract.sv
module mx_field_extract
  import mx_pkg::*;
(
  input  logic [IW-1:0] instr,
  output mx_fields_t    flds
);

  always_comb begin
    flds.slice = f_slice(instr);
    flds.vd    = instr[10:6];
    flds.vs    = instr[15:11];
    flds.vt    = instr[20:16];
    flds.fmt   = instr[25:21];
  end

endmodule

// File: rtl/mx_legal_check.sv
module mx_legal_check
  import mx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic [31:0]   instr_i,
  input  logic          cop1_usable_i,
  input  logic          media_en_i,
  input  logic          wide_en_i,
  input  logic          vext_en_i,
  output logic          done_o,
  output logic          issue_o,
  output logic          nop_o,
  output logic [1:0]    exc_o,
  output logic [2:0]    class_o,
  output logic [1:0]    slice_o,
  output logic [4:0]    vd_o,
  output logic [4:0]    vs_o,
  output logic [4:0]    vt_o,
  output logic [4:0]    fmt_o
);

  op_class_e  cls_d;
  logic       fmt_ok_d;
  exc_e       exc_d;
  mx_fields_t flds_d;
  logic       issue_d;
  logic       nop_d;

  mx_op_decode u_dec (
    .instr  (instr_i),
    .cls    (cls_d),
    .fmt_ok (fmt_ok_d)
  );

  mx_exc_prio u_prio (
    .cls         (cls_d),
    .fmt_ok      (fmt_ok_d),
    .cop1_usable (cop1_usable_i),
    .media_en    (media_en_i),
    .wide_en     (wide_en_i),
    .vext_en     (vext_en_i),
    .exc         (exc_d)
  );

  mx_field_extract u_fld (
    .instr (instr_i),
    .flds  (flds_d)
  );

  assign issue_d = (cls_d != OPC_NONE) && (exc_d == EXC_NONE);
  assign nop_d   = issue_d && f_is_acc(cls_d);

  op_class_e  cls_q;
  exc_e       exc_q;
  mx_fields_t flds_q;
  logic       done_q, issue_q, nop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      issue_q <= 1'b0;
      nop_q   <= 1'b0;
      exc_q   <= EXC_NONE;
      cls_q   <= OPC_NONE;
      flds_q  <= '0;
    end else if (valid_i) begin
      done_q  <= 1'b1;
      issue_q <= issue_d;
      nop_q   <= nop_d;
      exc_q   <= exc_d;
      cls_q   <= cls_d;
      flds_q  <= flds_d;
    end else begin
      done_q  <= 1'b0;
      issue_q <= 1'b0;
      nop_q   <= 1'b0;
      exc_q   <= EXC_NONE;
      cls_q   <= OPC_NONE;
    end
  end

  assign done_o  = done_q;
  assign issue_o = issue_q;
  assign nop_o   = nop_q;
  assign exc_o   = exc_q;
  assign class_o = cls_q;
  assign slice_o = flds_q.slice;
  assign vd_o    = flds_q.vd;
  assign vs_o    = flds_q.vs;
  assign vt_o    = flds_q.vt;
  assign fmt_o   = flds_q.fmt;

endmodule

// File: rtl/mx_legal_sva.sv
module mx_legal_sva (
  input logic        clk,
  input logic        rst,
  input logic        valid_i,
  input logic        cop1_usable_i,
  input logic        media_en_i,
  input logic        wide_en_i,
  input logic        vext_en_i,
  input logic        done_o,
  input logic        issue_o,
  input logic        nop_o,
  input logic [1:0]  exc_o,
  input logic [2:0]  class_o
);

  assert_done_follows_valid_R12: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> done_o);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> (!issue_o && exc_o == 2'd0 && !nop_o));

  assert_issue_clean_R11: assert property (@(posedge clk) disable iff (rst)
    issue_o |-> (exc_o == 2'd0 && class_o != 3'd0));

  assert_unhandled_silent_R1: assert property (@(posedge clk) disable iff (rst)
    (done_o && class_o == 3'd0) |-> (exc_o == 2'd0 && !issue_o));

  assert_cpu_first_R3: assert property (@(posedge clk) disable iff (rst)
    (done_o && class_o != 3'd0 && !$past(cop1_usable_i)) |-> exc_o == 2'd1);

  assert_media_second_R3: assert property (@(posedge clk) disable iff (rst)
    (done_o && class_o != 3'd0 && $past(cop1_usable_i) && !$past(media_en_i))
      |-> exc_o == 2'd2);

  assert_vendor_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (done_o && class_o >= 3'd3 && class_o <= 3'd5 && $past(cop1_usable_i) &&
     $past(media_en_i) && !$past(vext_en_i)) |-> exc_o == 2'd3);

  assert_nop_acc_R12: assert property (@(posedge clk) disable iff (rst)
    nop_o |-> (issue_o && (class_o == 3'd1 || class_o == 3'd2)));

endmodule

bind mx_legal_check mx_legal_sva u_sva (
  .clk           (clk),
  .rst           (rst),
  .valid_i       (valid_i),
  .cop1_usable_i (cop1_usable_i),
  .media_en_i    (media_en_i),
  .wide_en_i     (wide_en_i),
  .vext_en_i     (vext_en_i),
  .done_o        (done_o),
  .issue_o       (issue_o),
  .nop_o         (nop_o),
  .exc_o         (exc_o),
  .class_o       (class_o)
);

// File: tb/mx_legal_check_bench.sv
`timescale 1ns/1ps
module mx_legal_check_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic        cop1_usable_i = 1'b1;
  logic        media_en_i = 1'b1;
  logic        wide_en_i = 1'b1;
  logic        vext_en_i = 1'b1;
  logic        done_o, issue_o, nop_o;
  logic [1:0]  exc_o, slice_o;
  logic [2:0]  class_o;
  logic [4:0]  vd_o, vs_o, vt_o, fmt_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mx_legal_check u_mx_legal_check (
    .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
    .cop1_usable_i(cop1_usable_i), .media_en_i(media_en_i),
    .wide_en_i(wide_en_i), .vext_en_i(vext_en_i),
    .done_o(done_o), .issue_o(issue_o), .nop_o(nop_o), .exc_o(exc_o),
    .class_o(class_o), .slice_o(slice_o), .vd_o(vd_o), .vs_o(vs_o),
    .vt_o(vt_o), .fmt_o(fmt_o)
  );

  // Reference kind, restated from the requirements.
  function automatic logic [2:0] ref_kind(input logic [31:0] w);
    logic [1:0] s, q;
    s = w[25:24];
    q = w[23:22];
    if (w[31:26] != 6'b011110) return 3'd0;
    case (w[5:0])
      6'b111111: begin
        if (w[20:11] != 10'd0) return 3'd0;
        if (s != 2'b11 && q == 2'b00) return 3'd0;
        return 3'd1;
      end
      6'b111110: begin
        if (w[10:6] != 5'd0) return 3'd0;
        if ((s == 2'b00 || s == 2'b10) && q == 2'b00) return 3'd0;
        if (s == 2'b10 && w[20:16] != 5'd0) return 3'd0;
        return 3'd2;
      end
      6'b001001: return 3'd3;
      6'b110101: return (w[10:6] == 5'd0) ? 3'd4 : 3'd0;
      6'b001000: return 3'd5;
      default:   return 3'd0;
    endcase
  endfunction

  function automatic logic [1:0] ref_exc(input logic [31:0] w, input logic c1,
                                         input logic me, input logic we, input logic ve);
    logic [2:0] k;
    k = ref_kind(w);
    if (k == 3'd0) return 2'd0;
    if (!c1) return 2'd1;
    if (!me) return 2'd2;
    if (!we) return 2'd3;
    if (k >= 3'd3) begin
      if (!ve) return 2'd3;
      if (w[21]) return 2'd3;
    end else if (w[21]) return 2'd3;
    return 2'd0;
  endfunction

  task automatic fail_line(input string req, input string what, input int act, input int exp);
    n_fail++;
    $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  // Apply one word at a negedge, sample at the following negedge.
  task automatic run_word(input string req, input logic [31:0] w, input logic c1,
                          input logic me, input logic we, input logic ve);
    logic [2:0] ek;
    logic [1:0] ee;
    logic       ei, en;
    bit         bad;
    ek = ref_kind(w);
    ee = ref_exc(w, c1, me, we, ve);
    ei = (ek != 3'd0) && (ee == 2'd0);
    en = ei && (ek == 3'd1 || ek == 3'd2);
    instr_i = w; cop1_usable_i = c1; media_en_i = me; wide_en_i = we; vext_en_i = ve;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    n_tests++;
    bad = 1'b0;
    if (done_o !== 1'b1) begin fail_line(req, "done", done_o, 1); bad = 1'b1; end
    if (!bad && class_o !== ek) begin fail_line(req, "kind", class_o, ek); bad = 1'b1; end
    if (!bad && exc_o !== ee) begin fail_line(req, "exc", exc_o, ee); bad = 1'b1; end
    if (!bad && issue_o !== ei) begin fail_line(req, "issue", issue_o, ei); bad = 1'b1; end
    if (!bad && nop_o !== en) begin fail_line(req, "nop", nop_o, en); bad = 1'b1; end
    if (!bad && {slice_o, vd_o, vs_o, vt_o, fmt_o} !==
                {w[25:24], w[10:6], w[15:11], w[20:16], w[25:21]}) begin
      fail_line(req, "fields", {slice_o, vd_o, vs_o, vt_o, fmt_o},
                {w[25:24], w[10:6], w[15:11], w[20:16], w[25:21]});
    end
  endtask

  task automatic run_idle(input string req);
    valid_i = 1'b0;
    instr_i = $urandom;
    @(negedge clk);
    n_tests++;
    if (done_o !== 1'b0 || issue_o !== 1'b0 || nop_o !== 1'b0 || exc_o !== 2'd0)
      fail_line(req, "idle pulses", {done_o, issue_o, nop_o, exc_o}, 0);
  endtask

  function automatic logic [31:0] mk(input logic [4:0] fs, input logic [4:0] vt,
                                     input logic [4:0] vs, input logic [4:0] vd,
                                     input logic [5:0] fn);
    return {6'b011110, fs, vt, vs, vd, fn};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12: reset state
    n_tests++;
    if ({done_o, issue_o, nop_o, exc_o, class_o, slice_o, vd_o, vs_o, vt_o, fmt_o} !== '0)
      fail_line("R12", "reset outputs", {done_o, issue_o, exc_o, class_o}, 0);

    // R1: wrong major opcode
    run_word("R1", {6'b011111, 20'h0, 6'b001001}, 1, 1, 1, 1);
    run_word("R1", {6'b000000, 5'b00000, 15'h1234, 6'b111111}, 1, 1, 1, 1);
    // R2: each kind accepted, R11 unknown function
    run_word("R2", mk(5'b00000, 5'd3, 5'd4, 5'd5, 6'b001001), 1, 1, 1, 1);
    run_word("R2", mk(5'b00000, 5'd3, 5'd4, 5'd0, 6'b110101), 1, 1, 1, 1);
    run_word("R2", mk(5'b00000, 5'd7, 5'd8, 5'd9, 6'b001000), 1, 1, 1, 1);
    run_word("R2", mk(5'b10010, 5'd0, 5'd0, 5'd6, 6'b111111), 1, 1, 1, 1);
    run_word("R2", mk(5'b00010, 5'd2, 5'd6, 5'd0, 6'b111110), 1, 1, 1, 1);
    run_word("R11", mk(5'b00000, 5'd1, 5'd1, 5'd1, 6'b000111), 0, 0, 0, 0);
    // R3: priority order
    run_word("R3", mk(5'b00001, 5'd1, 5'd2, 5'd3, 6'b001001), 0, 0, 0, 0);
    run_word("R3", mk(5'b00000, 5'd1, 5'd2, 5'd3, 6'b001000), 1, 0, 0, 1);
    run_word("R3", mk(5'b00000, 5'd1, 5'd2, 5'd3, 6'b001000), 1, 1, 0, 1);
    run_word("R3", mk(5'b01000, 5'd0, 5'd0, 5'd3, 6'b111111), 0, 1, 1, 1);
    // R4: vendor gate, accumulator ops unaffected
    run_word("R4", mk(5'b00000, 5'd1, 5'd2, 5'd3, 6'b001001), 1, 1, 1, 0);
    run_word("R4", mk(5'b01000, 5'd0, 5'd0, 5'd3, 6'b111111), 1, 1, 1, 0);
    // R5: format select
    run_word("R5", mk(5'b00010, 5'd1, 5'd2, 5'd3, 6'b001000), 1, 1, 1, 1);
    run_word("R5", mk(5'b00001, 5'd1, 5'd2, 5'd3, 6'b001000), 1, 1, 1, 1);
    run_word("R5", mk(5'b00011, 5'd1, 5'd2, 5'd3, 6'b001001), 1, 1, 1, 1);
    run_word("R5", mk(5'b11100, 5'd1, 5'd2, 5'd0, 6'b110101), 1, 1, 1, 1);
    // R6: accumulator format bit
    run_word("R6", mk(5'b01001, 5'd0, 5'd0, 5'd3, 6'b111111), 1, 1, 1, 1);
    run_word("R6", mk(5'b00011, 5'd4, 5'd6, 5'd0, 6'b111110), 1, 1, 1, 1);
    // R7: read shape and slices
    run_word("R7", mk(5'b01010, 5'd0, 5'd1, 5'd3, 6'b111111), 1, 1, 1, 1);
    run_word("R7", mk(5'b01010, 5'd2, 5'd0, 5'd3, 6'b111111), 1, 1, 1, 1);
    run_word("R7", mk(5'b11110, 5'd0, 5'd0, 5'd31, 6'b111111), 1, 1, 1, 1);
    // R8: write shape
    run_word("R8", mk(5'b10010, 5'd5, 5'd6, 5'd0, 6'b111110), 1, 1, 1, 1);
    run_word("R8", mk(5'b10010, 5'd0, 5'd6, 5'd0, 6'b111110), 1, 1, 1, 1);
    run_word("R8", mk(5'b00110, 5'd5, 5'd6, 5'd1, 6'b111110), 1, 1, 1, 1);
    // R9: sub field on single-slice forms
    run_word("R9", mk(5'b00000, 5'd0, 5'd0, 5'd3, 6'b111111), 1, 1, 1, 1);
    run_word("R9", mk(5'b10000, 5'd0, 5'd4, 5'd0, 6'b111110), 1, 1, 1, 1);
    run_word("R9", mk(5'b11000, 5'd0, 5'd0, 5'd3, 6'b111111), 1, 1, 1, 1);
    run_word("R9", mk(5'b01000, 5'd2, 5'd4, 5'd0, 6'b111110), 1, 1, 1, 1);
    // R10: accumulate form has no destination
    run_word("R10", mk(5'b00000, 5'd1, 5'd2, 5'd8, 6'b110101), 1, 1, 1, 1);
    // R12: idle cycles and back-to-back strobes
    run_idle("R12");
    run_idle("R12");

    // R2 random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      logic [5:0]  fn;
      w = $urandom;
      case ($urandom_range(0, 5))
        0: fn = 6'b111111;
        1: fn = 6'b111110;
        2: fn = 6'b001001;
        3: fn = 6'b110101;
        4: fn = 6'b001000;
        default: fn = 6'($urandom);
      endcase
      w[5:0] = fn;
      if ($urandom_range(0, 9) != 0) w[31:26] = 6'b011110;
      if ($urandom_range(0, 1) == 0) w[20:16] = 5'd0;
      if ($urandom_range(0, 1) == 0) w[15:11] = 5'd0;
      if ($urandom_range(0, 1) == 0) w[10:6] = 5'd0;
      if ($urandom_range(0, 3) == 0) w[23:22] = 2'd0;
      run_word("R2", w, $urandom_range(0, 7) != 0, $urandom_range(0, 7) != 0,
               $urandom_range(0, 7) != 0, $urandom_range(0, 5) != 0);
      if ($urandom_range(0, 15) == 0) run_idle("R12");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule